// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat memory burst. A starting address is captured from the external address bus when either of two load strobes is asserted. After that, only the two least significant address bits change. The upper bits stay at the captured value until the next load.

The order of the low two bits depends on a mode input that is sampled at load time. In linear order the low bits count up by one and wrap modulo four. In interleaved order the low bits equal the start value XOR a beat counter. An active-low advance input steps the sequence. Holding advance high keeps the current address for a wait cycle.

Of the two strobes, one is gated by an active-low chip enable and is ignored while that enable is high. The other strobe acts on its own. All inputs are sampled on the rising clock edge. The output is the current address, taken directly from the held state.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives the address output to all zeros from the next edge.
- R2: A low controller strobe (`ld_ctl_n`) at a rising edge loads `addr_in` into the output, whatever the chip enable is.
- R3: A low processor strobe (`ld_cpu_n`) together with a low chip enable (`cs_n`) at a rising edge loads `addr_in` into the output.
- R4: While `cs_n` is high, a low `ld_cpu_n` has no effect. With advance high, the output stays unchanged.
- R5: With `burst_mode` low at load (linear), each advance adds one to output bits [1:0], modulo 4 (01, 10, 11, 00).
- R6: With `burst_mode` high at load (interleaved), output bits [1:0] equal the start value XOR the number of advances taken (start 01 gives 01, 00, 11, 10).
- R7: With no load and `adv_n` high, the output holds its value for that cycle.
- R8: Output bits above bit 1 keep the loaded value until the next load.
- R9: After the fourth beat, further advances wrap the beat count modulo 4 and repeat the same sequence.
- R10: `burst_mode` acts only at a load. Changing it during a burst does not change the order.
- R11: A load takes priority over a simultaneous advance. The output becomes the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip enable for the processor strobe, active low |
| ld_cpu_n | input | 1 | Processor load strobe, active low, gated by `cs_n` |
| ld_ctl_n | input | 1 | Controller load strobe, active low, ungated |
| adv_n | input | 1 | Advance to the next beat, active low; high means wait |
| burst_mode | input | 1 | 0 = linear order, 1 = interleaved order; sampled at load |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |

## Verification
Each of the four start offsets is run in both orders. Linear and interleaved sequences agree for start 00 and diverge for 01 and 11, so those starts separate an order mix-up.

Wait cycles are inserted mid-burst, and advances continue past the fourth beat. These patterns expose an advance sense error and a counter that saturates instead of wrapping.

Strobe patterns cover each strobe alone, the processor strobe with the enable high, and a load combined with an advance. These show which qualifier gates which strobe and that a load wins over an advance. A mode flip during a burst shows whether the order is held from the load.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          ld_cpu_n,
  input  logic          ld_ctl_n,
  input  logic          adv_n,
  input  logic          burst_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam int LW = 2;

  logic [AW-1:0] base_q;
  logic [LW-1:0] beat_q;
  logic          ilv_q;
  logic          load;
  logic [LW-1:0] low;

  assign load = (!ld_cpu_n && !cs_n) || !ld_ctl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      ilv_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
      ilv_q  <= burst_mode;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low      = ilv_q ? (base_q[LW-1:0] ^ beat_q) : (base_q[LW-1:0] + beat_q);
  assign addr_out = {base_q[AW-1:LW], low};
endmodule

module burst_addr_gen_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          ld_cpu_n,
  input logic          ld_ctl_n,
  input logic          adv_n,
  input logic          burst_mode,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out
);
  logic       c_load;
  logic       c_ilv;
  logic [1:0] c_start;
  logic [1:0] c_beat;

  assign c_load = (!ld_cpu_n && !cs_n) || !ld_ctl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_ilv <= 1'b0; c_start <= 2'b00; c_beat <= 2'b00;
    end else if (c_load) begin
      c_ilv <= burst_mode; c_start <= addr_in[1:0]; c_beat <= 2'b00;
    end else if (!adv_n) begin
      c_beat <= c_beat + 2'd1;
    end
  end

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld_ctl_n |=> addr_out == $past(addr_in)); // R2
  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ld_cpu_n && !cs_n) |=> addr_out == $past(addr_in)); // R3
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (!ld_cpu_n && cs_n && ld_ctl_n && adv_n) |=> $stable(addr_out)); // R4
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!c_load && !adv_n && !c_ilv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R5
  AST_ILV_STEP: assert property (@(posedge clk) disable iff (rst)
    (c_ilv && !$past(c_load)) |-> addr_out[1:0] == (c_start ^ c_beat)); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!c_load && adv_n) |=> $stable(addr_out)); // R7
  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !c_load |=> $stable(addr_out[AW-1:2])); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, adv_n = 1'b1, burst_mode = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int checks = 0, errors = 0;
  int m_base = 0, m_beat = 0, m_ilv = 0;
  bit done = 0;

  burst_addr_gen #(.AW(AW)) u_dut (.*);

  always #4 clk = ~clk;

  function automatic int expect_addr();
    int lo;
    lo = m_ilv ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic cyc(input bit r, input bit cs, input bit lcpu, input bit lctl,
                     input bit adv, input bit md, input int a, input string tag);
    rst = r; cs_n = cs; ld_cpu_n = lcpu; ld_ctl_n = lctl; adv_n = adv;
    burst_mode = md; addr_in = AW'(a);
    @(posedge clk);
    if (r) begin m_base = 0; m_beat = 0; m_ilv = 0; end
    else if ((!lcpu && !cs) || !lctl) begin m_base = a; m_beat = 0; m_ilv = md; end
    else if (!adv) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    checks++;
    if (int'(addr_out) != expect_addr()) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, addr_out, AW'(expect_addr()));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 1, 1, 0, 'h1ABCD, "R1 reset");
    cyc(1, 0, 0, 1, 0, 1, 'h1ABCD, "R1 reset holds zero");
    // linear bursts from each start offset
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 1, 0, 1, 0, 'h12340 + s, "R2 ctl load, cs high");
      for (int k = 0; k < 6; k++) cyc(0, 1, 1, 1, 0, 0, 'h0, "R5 R9 linear step/wrap");
    end
    // interleaved bursts
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 0, 1, 1, 1, 'h0F0F0 + s, "R3 cpu load");
      for (int k = 0; k < 6; k++) cyc(0, 1, 1, 1, 0, 1, 'h1FFFF, "R6 R9 R8 interleaved step/wrap");
    end
    // waits inside a burst
    cyc(0, 1, 1, 0, 1, 1, 'h05555, "R2 load interleaved");
    cyc(0, 1, 1, 1, 1, 1, 'h0AAAA, "R7 wait");
    cyc(0, 1, 1, 1, 0, 1, 'h0AAAA, "R6 step");
    cyc(0, 1, 1, 1, 1, 1, 'h0AAAA, "R7 wait");
    cyc(0, 1, 1, 1, 1, 0, 'h0AAAA, "R7 wait");
    cyc(0, 1, 1, 1, 0, 1, 'h0AAAA, "R6 step after wait");
    // processor strobe gated off
    cyc(0, 1, 0, 1, 1, 0, 'h1FFFC, "R4 cpu strobe ignored");
    cyc(0, 1, 0, 1, 0, 0, 'h1FFFC, "R4 cpu strobe ignored with advance");
    // mode flip mid-burst
    cyc(0, 0, 0, 1, 1, 0, 'h00003, "R3 load linear");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R10 mode ignored mid-burst");
    cyc(0, 1, 1, 1, 0, 1, 'h0, "R10 mode ignored mid-burst");
    cyc(0, 1, 1, 1, 0, 0, 'h0, "R10 linear continues");
    // load beats advance
    cyc(0, 1, 1, 1, 0, 0, 'h0, "R5 step");
    cyc(0, 1, 1, 0, 0, 1, 'h16661, "R11 load over advance");
    cyc(0, 0, 0, 1, 0, 0, 'h08882, "R11 cpu load over advance");
    cyc(0, 1, 1, 1, 0, 0, 'h0, "R8 upper frozen");
    cyc(1, 1, 1, 1, 0, 0, 'h0, "R1 reset mid-burst");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule